// File: doc/BRIEF.md
# Coincident Edge Sync Pulse Generator

This block produces an active-low synchronisation strobe for two divided clocks, called bank A and bank C, that are both derived from one fast master clock and start in phase. Whenever the two divided clocks are about to rise on the same master-clock edge, the strobe goes low for exactly one period of the faster divided clock. That low interval ends on the shared rising edge. System logic can use the strobe as a baseline marker when the two frequencies are not integer multiples of each other.

Both divided clocks are modelled inside the block by a pair of phase counters. One counts modulo the bank A ratio and the other modulo the bank C ratio. The block does not compute the common hyperperiod. It asserts the strobe when both counters are the same number of master cycles away from their next wrap. The strobe is registered in the master clock domain. The ratios are expected to change only while reset is held.

Top module: `sync_pulse_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after its release, `sync_n` is high.
- R2: With unequal effective ratios A and C, let t be the number of master rising edges since reset release, L = lcm(A, C) and m = min(A, C). Then `sync_n` is low exactly when (t mod L) >= L - m. The low interval ends at the next common rising edge, which falls on a multiple of L.
- R3: With unequal ratios, every low pulse lasts exactly m master cycles, which is one period of the faster divided clock.
- R4: With unequal ratios, `sync_n` is high at every count outside the window of R2.
- R5: With equal effective ratios N, `sync_n` is low exactly when (t mod N) >= N - floor(N/2). It therefore follows the low phase of the divided clock and toggles at that clock's rate. For N = 1 it stays high.
- R6: A ratio input of 0 acts as a ratio of 1.
- R7: Reset restarts both phase counters together, so the first low pulse after any reset, even one applied in the middle of a hyperperiod, ends exactly L edges after the reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ratio_a | input | RW | Bank A divide ratio in master cycles (0 is treated as 1) |
| ratio_c | input | RW | Bank C divide ratio in master cycles (0 is treated as 1) |
| sync_n | output | 1 | Active-low coincidence strobe, registered |

## Verification
The hardest situation to reach is a pair of ratios whose common hyperperiod is long compared with either period, such as 7 against 8. There the single coincidence window appears only once every 56 master cycles, while both counters wrap many times between windows. The bench reaches it by sweeping every pair of ratio values from 0 to 8. For each pair it applies a fresh reset, often in the middle of the previous pair's hyperperiod, and then runs more than two full hyperperiods. At every cycle it compares the strobe with a value derived from lcm and min.

// File: rtl/sync_pulse_gen.sv
module sync_pulse_gen #(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] ratio_a,
  input  logic [RW-1:0] ratio_c,
  output logic          sync_n
);

  logic [RW-1:0] na, nc;
  logic [RW-1:0] pa, pc;
  logic [RW-1:0] pa_nx, pc_nx;
  logic          same;
  logic          hit;

  assign na = (ratio_a == '0) ? RW'(1) : ratio_a;
  assign nc = (ratio_c == '0) ? RW'(1) : ratio_c;

  assign pa_nx = (pa >= na - RW'(1)) ? '0 : pa + RW'(1);
  assign pc_nx = (pc >= nc - RW'(1)) ? '0 : pc + RW'(1);

  assign same = (na == nc);

  // distance to next wrap is equal on both sides only inside the window
  assign hit = same ? (pa_nx >= (na - (na >> 1)))
                    : ((na - pa_nx) == (nc - pc_nx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa     <= '0;
      pc     <= '0;
      sync_n <= 1'b1;
    end else begin
      pa     <= pa_nx;
      pc     <= pc_nx;
      sync_n <= ~hit;
    end
  end

endmodule

// File: rtl/sync_pulse_gen_chk.sv
module sync_pulse_gen_chk #(
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [RW-1:0] ratio_a,
  input logic [RW-1:0] ratio_c,
  input logic          sync_n
);

  logic [RW-1:0] ea, ec, mn;
  logic [RW:0]   lrun;

  assign ea = (ratio_a == '0) ? RW'(1) : ratio_a;
  assign ec = (ratio_c == '0) ? RW'(1) : ratio_c;
  assign mn = (ea < ec) ? ea : ec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lrun <= '0;
    else if (!sync_n) lrun <= lrun + 1'b1;
    else              lrun <= '0;
  end

  p_low_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n |-> (lrun < {1'b0, mn}));

  p_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((ea != ec) && $rose(sync_n)) |-> (lrun == {1'b0, mn}));

  p_equal_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((ea == ec) && $rose(sync_n)) |-> (lrun == {1'b0, ea >> 1}));

  p_unit_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((ea == RW'(1)) && (ec == RW'(1))) |-> sync_n);

endmodule

bind sync_pulse_gen sync_pulse_gen_chk #(.RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ratio_a(ratio_a), .ratio_c(ratio_c), .sync_n(sync_n)
);

// File: tb/sync_pulse_gen_bench.sv
module sync_pulse_gen_bench;
  localparam int RW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [RW-1:0] ratio_a = '0;
  logic [RW-1:0] ratio_c = '0;
  logic          sync_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  sync_pulse_gen #(.RW(RW)) u_sync_pulse_gen (
    .clk(clk), .rst_n(rst_n), .ratio_a(ratio_a), .ratio_c(ratio_c), .sync_n(sync_n)
  );

  function automatic int gcd(int x, int y);
    while (y != 0) begin
      int r = x % y;
      x = y;
      y = r;
    end
    return x;
  endfunction

  function automatic bit expect_high(int a, int c, int t);
    int l, m;
    if (a == c) return (t % a) < (a - a / 2);
    l = a / gcd(a, c) * c;
    m = (a < c) ? a : c;
    return (t % l) < (l - m);
  endfunction

  task automatic check(string tag, logic act, logic exp, int a, int c, int t);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: a=%0d c=%0d t=%0d sync_n=%b expected %b", tag, a, c, t, act, exp);
    end
  endtask

  task automatic run_pair(int ra, int rc, int cycles);
    int a = (ra == 0) ? 1 : ra;
    int c = (rc == 0) ? 1 : rc;
    int l = a / gcd(a, c) * c;
    int m = (a < c) ? a : c;
    @(negedge clk);
    rst_n   = 1'b0;
    ratio_a = RW'(ra);
    ratio_c = RW'(rc);
    @(negedge clk);
    check("R1", sync_n, 1'b1, a, c, 0);
    rst_n = 1'b1;
    for (int t = 1; t <= cycles; t++) begin
      bit eh;
      string tag;
      @(negedge clk);
      eh = expect_high(a, c, t);
      if (ra == 0 || rc == 0)            tag = "R6";
      else if (a == c)                   tag = "R5";
      else if (t < l && !eh)             tag = "R7";
      else if (!eh)                      tag = "R2 R3";
      else                               tag = "R4";
      check(tag, sync_n, eh, a, c, t);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    for (int ra = 0; ra <= 8; ra++) begin
      for (int rc = 0; rc <= 8; rc++) begin
        int a = (ra == 0) ? 1 : ra;
        int c = (rc == 0) ? 1 : rc;
        run_pair(ra, rc, 2 * (a / gcd(a, c) * c) + 3);
      end
    end
    // R7: reset in mid-hyperperiod, then full run
    run_pair(7, 8, 20);
    run_pair(7, 8, 120);
    run_pair(3, 4, 5);
    run_pair(4, 6, 30);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule